// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a successive-approximation analog-to-digital converter. It divides the peripheral clock down to a slower conversion clock. It accepts a start request from either a software strobe or a hardware event, and it aligns that request to the conversion clock. It then walks the converter through three phases:

- a sampling phase;
- an optional amplifier settling delay;
- a binary search that resolves two result bits per conversion-clock period, most significant bit first.

The block drives the trial code to the external DAC and reads back a single comparator decision. When the search ends, it stores the final code and raises a sticky completion flag.

Resolution is 8 or 12 bits. The gain delay is 0 to 3 extra conversion-clock periods. Both are captured when a conversion begins, so later changes on those inputs do not disturb a conversion already in flight. A request that arrives during a conversion is held. The next conversion then begins on the conversion-clock period right after the current one finishes, with no idle period between them.

All logic runs on the peripheral clock. The conversion clock is represented by an enable counter, and its level is also brought out for the analog side. The reset input is asynchronous and active low. It is expected to have been released synchronously upstream.

Top module: `sar_conv_seq`

## Requirements
- R1: One conversion-clock period lasts 4·2^sel peripheral cycles, where sel = `presc_sel_i` (0..7). `adc_clk_o` is high for the first half of each period and low for the second half.
- R2: A start request (`sw_start_i` or `evt_start_i`, high for one cycle) made at least one peripheral cycle before a conversion-clock period boundary starts a conversion at that boundary. A request made in the last peripheral cycle of a period starts the conversion one period later.
- R3: `sample_o` is high only during the first half of the first conversion-clock period of each conversion. `busy_o` rises together with it.
- R4: From the rise of `busy_o` to the completion, exactly (1 + N/2 + G) conversion-clock periods elapse. N is the resolution and G = `gain_i` is the number of extra periods.
- R5: The code under test has the current bit set to 1. Two bits are decided in each search period, msb first: one at mid-period and one at period end. A bit is kept only if `cmp_i` is high at its decision point. So with an ideal comparator (`cmp_i` = trial ≤ input) the result equals the input.
- R6: In 8-bit mode (`res12_i` = 0) the result sits in bits 7:0 and bits 11:8 read 0. An input above 255 gives 255.
- R7: `done_o` is set on completion. It stays set until `clr_done_i` is high or a new conversion begins. A completion in the same cycle overrides either clear.
- R8: `result_o` keeps its value from one completion until the next, including across a flag clear.
- R9: A request made while a conversion is running starts the next conversion on the period right after completion. `busy_o` stays high and the new result appears one full conversion time later.
- R10: Resolution and gain are captured at the start of a conversion. Changing `res12_i` or `gain_i` afterwards does not change that conversion's length or result.
- R11: After reset, `busy_o`, `done_o`, `sample_o`, `trial_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel_i | input | 3 | Conversion-clock divide select, ratio 4·2^sel |
| res12_i | input | 1 | 1 = 12-bit result, 0 = 8-bit result |
| gain_i | input | 2 | Extra gain settling periods (0..3) |
| sw_start_i | input | 1 | Software start strobe |
| evt_start_i | input | 1 | Event start strobe |
| clr_done_i | input | 1 | Clears the completion flag |
| cmp_i | input | 1 | Comparator decision, 1 = input ≥ trial code |
| adc_clk_o | output | 1 | Conversion clock level |
| sample_o | output | 1 | Sample-and-hold tracking window |
| busy_o | output | 1 | Conversion in progress |
| trial_o | output | 12 | Trial code driven to the DAC |
| result_o | output | 12 | Last completed result, right aligned |
| done_o | output | 1 | Sticky completion flag |

## Verification
The bench times start requests against the conversion-clock phase. This catches a design that samples the raw request at the period boundary, because such a design would start one period early on a late request. Latency is measured for every combination of resolution, gain and divide ratio exercised. An off-by-one in the gain or bit counters shows up there as a conversion that is one period too long or too short. It also shows up as a result with a dropped lsb.

Back-to-back requests, flag clears and mid-conversion configuration changes are also tested. A design that lets a pending request collide with completion would show an idle gap or lose the result. A design that reads the live configuration would change its own length in mid-flight. An 8-bit conversion with an input above full scale exposes a design that leaks search bits into the upper nibble.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_MAX = 12;
  localparam int RES_MIN = 8;
  localparam int SEL_W   = 3;
  localparam int GAIN_W  = 2;
  localparam int DIV_MIN_SHIFT = 2;
  localparam int IDX_W   = $clog2(RES_MAX);
  localparam int CNT_W   = DIV_MIN_SHIFT + (1 << SEL_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_GAIN   = 2'd2,
    ST_BITS   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int SEL_W = 3,
  parameter int MIN_SHIFT = 2,
  localparam int CNT_W = MIN_SHIFT + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_mid_o,
  output logic             tick_end_o,
  output logic             clk_hi_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim, half;

  always_comb begin
    lim  = CNT_W'((1 << (int'(sel_i) + MIN_SHIFT)) - 1);
    half = lim >> 1;
    tick_end_o = (cnt_q >= lim);
    tick_mid_o = (cnt_q == half);
    clk_hi_o   = (cnt_q <= half);
    cnt_d = tick_end_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end_o |=> (cnt_q == '0));
endmodule

// File: rtl/sar_start_gate.sv
module sar_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req_i,
  input  logic evt_req_i,
  input  logic consume_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (consume_i) pend_d = 1'b0;
    else           pend_d = pend_q | sw_req_i | evt_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R2
  pend_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !pend_o);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_MAX = 12,
  parameter int RES_MIN = 8,
  localparam int IDX_W = $clog2(RES_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic               res12_i,
  input  logic               decide_i,
  input  logic [IDX_W-1:0]   bidx_i,
  input  logic               cmp_i,
  output logic [RES_MAX-1:0] code_o,
  output logic [RES_MAX-1:0] dec_o
);
  logic [RES_MAX-1:0] code_q, code_d, seed;

  for (genvar i = 0; i < RES_MAX; i++) begin : g_bit
    localparam bit HI_SEED = (i == RES_MAX - 1);
    localparam bit LO_SEED = (i == RES_MIN - 1);
    always_comb begin
      seed[i] = res12_i ? HI_SEED : LO_SEED;
      if (bidx_i == IDX_W'(i))          dec_o[i] = cmp_i;
      else if (bidx_i == IDX_W'(i + 1)) dec_o[i] = 1'b1;
      else                              dec_o[i] = code_q[i];
    end
  end

  always_comb begin
    if (clear_i)       code_d = '0;
    else if (load_i)   code_d = seed;
    else if (decide_i) code_d = dec_o;
    else               code_d = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  // R5
  single_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> ($countones(code_q) == 1));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   presc_sel_i,
  input  logic               res12_i,
  input  logic [GAIN_W-1:0]  gain_i,
  input  logic               sw_start_i,
  input  logic               evt_start_i,
  input  logic               clr_done_i,
  input  logic               cmp_i,
  output logic               adc_clk_o,
  output logic               sample_o,
  output logic               busy_o,
  output logic [RES_MAX-1:0] trial_o,
  output logic [RES_MAX-1:0] result_o,
  output logic               done_o
);
  sar_state_e         st_q, st_d;
  logic [GAIN_W-1:0]  gcnt_q, gcnt_d, gain_q, gain_d;
  logic [IDX_W-1:0]   bidx_q, bidx_d;
  logic               res12_q, res12_d;
  logic               done_q, done_d;
  logic [RES_MAX-1:0] result_q, result_d, dec;
  logic               tick_mid, tick_end, clk_hi, pend;
  logic               launch, load, finish, decide;

  sar_prescaler #(.SEL_W(SEL_W), .MIN_SHIFT(DIV_MIN_SHIFT)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_i(presc_sel_i),
    .tick_mid_o(tick_mid), .tick_end_o(tick_end), .clk_hi_o(clk_hi)
  );

  sar_start_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_start_i), .evt_req_i(evt_start_i),
    .consume_i(launch), .pend_o(pend)
  );

  sar_approx_reg #(.RES_MAX(RES_MAX), .RES_MIN(RES_MIN)) u_approx (
    .clk(clk), .rst_n(rst_n), .clear_i(launch), .load_i(load),
    .res12_i(res12_q), .decide_i(decide), .bidx_i(bidx_q), .cmp_i(cmp_i),
    .code_o(trial_o), .dec_o(dec)
  );

  always_comb begin
    st_d    = st_q;
    gcnt_d  = gcnt_q;
    bidx_d  = bidx_q;
    res12_d = res12_q;
    gain_d  = gain_q;
    launch  = 1'b0;
    load    = 1'b0;
    finish  = 1'b0;
    decide  = (st_q == ST_BITS) && (tick_mid || tick_end);
    unique case (st_q)
      ST_IDLE: begin
        if (tick_end && pend) begin
          launch  = 1'b1;
          st_d    = ST_SAMPLE;
          res12_d = res12_i;
          gain_d  = gain_i;
        end
      end
      ST_SAMPLE: begin
        if (tick_end) begin
          load   = 1'b1;
          bidx_d = res12_q ? IDX_W'(RES_MAX - 1) : IDX_W'(RES_MIN - 1);
          if (gain_q == '0) begin
            st_d = ST_BITS;
          end else begin
            st_d   = ST_GAIN;
            gcnt_d = gain_q - 1'b1;
          end
        end
      end
      ST_GAIN: begin
        if (tick_end) begin
          if (gcnt_q == '0) st_d = ST_BITS;
          else              gcnt_d = gcnt_q - 1'b1;
        end
      end
      ST_BITS: begin
        if (decide) begin
          if (tick_end && bidx_q == '0) begin
            finish = 1'b1;
            if (pend) begin
              launch  = 1'b1;
              st_d    = ST_SAMPLE;
              res12_d = res12_i;
              gain_d  = gain_i;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            bidx_d = bidx_q - 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (finish)                    done_d = 1'b1;
    else if (clr_done_i || launch) done_d = 1'b0;
    else                           done_d = done_q;
    result_d = finish ? dec : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      gcnt_q   <= '0;
      gain_q   <= '0;
      bidx_q   <= '0;
      res12_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      st_q     <= st_d;
      gcnt_q   <= gcnt_d;
      gain_q   <= gain_d;
      bidx_q   <= bidx_d;
      res12_q  <= res12_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign adc_clk_o = clk_hi;
  assign sample_o  = (st_q == ST_SAMPLE) && clk_hi;
  assign busy_o    = (st_q != ST_IDLE);
  assign result_o  = result_q;
  assign done_o    = done_q;

  // R3
  first_is_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sample_o);

  // R4
  done_after_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(st_q == ST_BITS));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done_i && !finish) |=> !done_q);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> done_q);
endmodule

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
module sar_conv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  presc_sel;
  logic        res12;
  logic [1:0]  gain;
  logic        sw_start, evt_start, clr_done, cmp;
  logic        adc_clk, sample, busy, done;
  logic [11:0] trial, result;
  logic [11:0] vin;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign cmp = (trial <= vin);

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .presc_sel_i(presc_sel), .res12_i(res12),
    .gain_i(gain), .sw_start_i(sw_start), .evt_start_i(evt_start),
    .clr_done_i(clr_done), .cmp_i(cmp), .adc_clk_o(adc_clk),
    .sample_o(sample), .busy_o(busy), .trial_o(trial),
    .result_o(result), .done_o(done)
  );

  // vector: [17]=res12 [16:15]=gain [14:12]=sel [11:0]=input
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd0, 12'd0},
    {1'b0, 2'd0, 3'd0, 12'd255},
    {1'b0, 2'd1, 3'd0, 12'h0A5},
    {1'b1, 2'd0, 3'd0, 12'hFFF},
    {1'b1, 2'd3, 3'd1, 12'h800},
    {1'b1, 2'd2, 3'd2, 12'd1234},
    {1'b0, 2'd3, 3'd7, 12'd77},
    {1'b0, 2'd0, 3'd1, 12'd300},
    {1'b1, 2'd1, 3'd0, 12'h7FF}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_start(bit use_evt);
    if (use_evt) evt_start = 1'b1; else sw_start = 1'b1;
    tick();
    evt_start = 1'b0;
    sw_start  = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 20000; i++) begin
      if (busy) break;
      tick();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      tick();
    end
  endtask

  task automatic sync_period();
    logic prev;
    prev = adc_clk;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (adc_clk && !prev) break;
      prev = adc_clk;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, sc, lat, div, expv;
    rst_n = 1'b0; presc_sel = '0; res12 = 1'b0; gain = '0;
    sw_start = 1'b0; evt_start = 1'b0; clr_done = 1'b0; vin = '0;
    repeat (3) tick();
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 sample", sample, 0);
    chk("R11 trial", trial, 0);
    chk("R11 result", result, 0);
    rst_n = 1'b1;
    tick();

    // R4 R5 R6 R3: vector table
    for (int v = 0; v < NV; v++) begin
      res12 = VEC[v][17]; gain = VEC[v][16:15];
      presc_sel = VEC[v][14:12]; vin = VEC[v][11:0];
      div = 4 << presc_sel;
      lat = (1 + int'(gain) + (res12 ? 6 : 4)) * div;
      expv = res12 ? int'(vin) : ((vin > 255) ? 255 : int'(vin));
      tick();
      pulse_start(v[0]);
      wait_busy();
      sc = sample ? 1 : 0;
      n = 0;
      for (int i = 0; i < 20000; i++) begin
        tick();
        n++;
        if (sample) sc++;
        if (done) break;
      end
      chk($sformatf("R4 latency v%0d", v), n, lat);
      chk($sformatf("R5 R6 result v%0d", v), result, expv);
      chk($sformatf("R3 sample width v%0d", v), sc, div / 2);
      wait_idle();
    end

    // R1: conversion clock shape with divide 16
    presc_sel = 3'd2;
    sync_period();
    n = 0;
    while (adc_clk && n < 100) begin tick(); n++; end
    chk("R1 high half", n, 8);
    n = 0;
    while (!adc_clk && n < 100) begin tick(); n++; end
    chk("R1 low half", n, 8);

    // R2: request two cycles before the boundary starts at that boundary
    presc_sel = 3'd1; res12 = 1'b0; gain = '0; vin = 12'd10;
    sync_period();
    repeat (6) tick();
    pulse_start(1'b0);
    chk("R2 early not yet busy", busy, 0);
    tick();
    chk("R2 early starts at boundary", busy, 1);
    wait_idle();
    // R2: request in the last cycle is deferred a whole period
    sync_period();
    repeat (7) tick();
    pulse_start(1'b1);
    repeat (7) tick();
    chk("R2 late deferred", busy, 0);
    tick();
    chk("R2 late starts next period", busy, 1);
    wait_idle();

    // R7 R8: clear input, then start-clear
    chk("R7 flag set", done, 1);
    clr_done = 1'b1;
    tick();
    clr_done = 1'b0;
    chk("R7 clear input", done, 0);
    chk("R8 result kept over clear", result, 10);
    vin = 12'd20;
    pulse_start(1'b0);
    wait_busy();
    wait_idle();
    chk("R7 flag set again", done, 1);
    pulse_start(1'b0);
    wait_busy();
    chk("R7 start clears flag", done, 0);
    chk("R8 result held during conversion", result, 20);
    wait_idle();

    // R9: back-to-back conversions
    presc_sel = 3'd0; res12 = 1'b0; gain = '0; vin = 12'd100;
    tick();
    pulse_start(1'b0);
    wait_busy();
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      tick();
      n++;
      if (n == 5) sw_start = 1'b1;
      if (n == 6) sw_start = 1'b0;
      if (done) break;
    end
    chk("R9 first latency", n, 20);
    chk("R9 first result", result, 100);
    chk("R9 no idle gap", busy, 1);
    vin = 12'd200;
    repeat (19) tick();
    chk("R8 result held until next completion", result, 100);
    tick();
    chk("R9 second result", result, 200);
    chk("R9 flag set", done, 1);
    wait_idle();

    // R10: configuration change mid-conversion
    presc_sel = 3'd1; res12 = 1'b1; gain = 2'd2; vin = 12'd3000;
    tick();
    pulse_start(1'b1);
    wait_busy();
    res12 = 1'b0; gain = 2'd0;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      tick();
      n++;
      if (done) break;
    end
    chk("R10 latency uses captured config", n, 72);
    chk("R10 result uses captured resolution", result, 3000);
    wait_idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule